// File: doc/BRIEF.md
# Banked Segment Display RAM

This block is the display memory of a segment LCD driver. It holds one small word per segment line: word address N feeds segment line N, and bit k of every word belongs to backplane k. A scan engine asks for one backplane at a time and receives the full row of segment values for that backplane in the same cycle.

A host fills the memory through a write pointer. It loads the pointer with a start address, then issues one or more write strobes. Each strobe stores one word's worth of data at the pointer, and the pointer then moves to the next address, wrapping at the top. How many bits of each word a strobe touches depends on the drive mode: one, two, three or four backplanes.

In the one-backplane and two-backplane modes the unused upper bits form a second bank. An input bank selector steers writes into that bank. An output bank selector, set independently, chooses which bank the scan engine sees. The host can therefore build a new image while the current one stays on the glass, then switch to it in a single step. The serial host bus and the analog drive are not part of this block.

Top module: `banked_seg_ram`

## Requirements
- R1: After reset every stored bit reads 0 and the write pointer is 0, so the first write without a pointer load lands at address 0.
- R2: With no bank remap, `rd_seg[n]` equals bit `rd_bp` of word n, for every segment n and every backplane index.
- R3: Each `wr_en` cycle stores data at the current pointer, and the pointer then advances by one, so successive strobes fill consecutive addresses.
- R4: The pointer wraps from address NUM_SEG-1 (31) to address 0.
- R5: `ptr_load` sets the pointer to `ptr_value`. When `ptr_load` and `wr_en` are high in the same cycle, the write goes to `ptr_value` and the pointer ends at `ptr_value`+1.
- R6: `drive_mode` encodes 0 = static, 1 = two backplanes, 2 = three backplanes, 3 = four backplanes. With the input bank clear, a write stores `wr_data[m:0]` into bits m:0, where m = `drive_mode`. All other bits of the word keep their values.
- R7: With `in_bank` set, a static write stores `wr_data[0]` into bit 2, and a two-backplane write stores `wr_data[1:0]` into bits 3:2. Bits 1:0 keep their values.
- R8: With `out_bank` set, a static-mode read of backplane 0 returns bit 2. A two-backplane read of backplanes 0 and 1 returns bits 2 and 3. Other backplane indices read as normal.
- R9: The selectors are independent: `out_bank` has no effect on where writes land, and `in_bank` has no effect on what is read.
- R10: In three-backplane and four-backplane modes, `in_bank` and `out_bank` have no effect.
- R11: In a cycle without `wr_en`, no stored bit changes, whatever `wr_data` and `in_bank` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_mode | input | 2 | Drive mode: 0 static, 1 two, 2 three, 3 four backplanes |
| ptr_load | input | 1 | Load the write pointer from `ptr_value` |
| ptr_value | input | 5 | Start address for the pointer |
| wr_en | input | 1 | Store `wr_data` at the pointer and advance it |
| wr_data | input | 4 | Write data, low bits used first |
| in_bank | input | 1 | Steer writes to the upper bank (static and two-backplane modes) |
| out_bank | input | 1 | Show the upper bank (static and two-backplane modes) |
| rd_bp | input | 2 | Backplane index requested by the scan engine |
| rd_seg | output | 32 | Segment values for the requested backplane |

## Verification
The bench builds the block with its default parameters: 32 segment words and 4 backplanes. With these values the wrap from address 31 to 0 is reached with a short run of writes, and all four drive modes exist. Only at four backplanes do both banks of the two-backplane mode fit, so every remap case of R7 and R8 can be tried. A bench-side model of the memory and pointer predicts every row the scan port should show after each write sequence.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;
    typedef enum logic [1:0] {
        DRV_STATIC = 2'd0,
        DRV_MUX2   = 2'd1,
        DRV_MUX3   = 2'd2,
        DRV_MUX4   = 2'd3
    } drive_mode_e;

    // first bit column of the alternate bank
    localparam int ALT_BANK_BASE = 2;
endpackage

// File: rtl/seg_ptr.sv
module seg_ptr #(
    parameter int NUM_SEG = 32,
    localparam int AW = $clog2(NUM_SEG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic          wr_en,
    output logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] LAST = AW'(NUM_SEG - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        wr_addr = ptr_load ? ptr_value : s_q.ptr;
        if (ptr_load)
            s_d.ptr = ptr_value;
        if (wr_en)
            s_d.ptr = (wr_addr == LAST) ? '0 : wr_addr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the pointer wraps at the top address
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load && s_q.ptr == LAST) |=> (s_q.ptr == '0));

    // R3: a write without a load advances the pointer by one
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load && s_q.ptr != LAST) |=> (s_q.ptr == $past(s_q.ptr) + AW'(1)));

    // R5: a load without a write sets the pointer
    assert_ptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !wr_en) |=> (s_q.ptr == $past(ptr_value)));
endmodule

// File: rtl/seg_lane_map.sv
module seg_lane_map
    import seg_ram_pkg::*;
#(
    parameter int NUM_BP = 4,
    localparam int BPW = $clog2(NUM_BP)
) (
    input  logic [1:0]        drive_mode,
    input  logic              in_bank,
    input  logic [NUM_BP-1:0] wr_data,
    output logic [NUM_BP-1:0] lane_mask,
    output logic [NUM_BP-1:0] lane_data
);
    drive_mode_e mode;
    int          active;
    int          offset;

    always_comb begin
        mode   = drive_mode_e'(drive_mode);
        active = int'(drive_mode) + 1;
        offset = (in_bank && (mode == DRV_STATIC || mode == DRV_MUX2)) ? ALT_BANK_BASE : 0;
        lane_mask = '0;
        lane_data = '0;
        for (int k = 0; k < NUM_BP; k++) begin
            if (k >= offset && k < offset + active) begin
                lane_mask[k] = 1'b1;
                lane_data[k] = wr_data[BPW'(k - offset)];
            end
        end
    end
endmodule

// File: rtl/seg_col_sel.sv
module seg_col_sel
    import seg_ram_pkg::*;
#(
    parameter int NUM_BP = 4,
    localparam int BPW = $clog2(NUM_BP)
) (
    input  logic [1:0]     drive_mode,
    input  logic           out_bank,
    input  logic [BPW-1:0] rd_bp,
    output logic [BPW-1:0] col
);
    drive_mode_e mode;
    logic        remap;

    always_comb begin
        mode  = drive_mode_e'(drive_mode);
        remap = out_bank &&
                ((mode == DRV_STATIC && int'(rd_bp) == 0) ||
                 (mode == DRV_MUX2   && int'(rd_bp) < 2));
        col   = remap ? rd_bp + BPW'(ALT_BANK_BASE) : rd_bp;
    end
endmodule

// File: rtl/banked_seg_ram.sv
module banked_seg_ram
    import seg_ram_pkg::*;
#(
    parameter int NUM_SEG = 32,
    parameter int NUM_BP  = 4,
    localparam int AW  = $clog2(NUM_SEG),
    localparam int BPW = $clog2(NUM_BP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         drive_mode,
    input  logic               ptr_load,
    input  logic [AW-1:0]      ptr_value,
    input  logic               wr_en,
    input  logic [NUM_BP-1:0]  wr_data,
    input  logic               in_bank,
    input  logic               out_bank,
    input  logic [BPW-1:0]     rd_bp,
    output logic [NUM_SEG-1:0] rd_seg
);
    typedef struct packed {
        logic [NUM_SEG-1:0][NUM_BP-1:0] mem;
    } ram_state_t;

    ram_state_t         s_d, s_q;
    logic [AW-1:0]      wr_addr;
    logic [NUM_BP-1:0]  lane_mask;
    logic [NUM_BP-1:0]  lane_data;
    logic [BPW-1:0]     col;

    seg_ptr #(.NUM_SEG(NUM_SEG)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_load),
        .ptr_value (ptr_value),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr)
    );

    seg_lane_map #(.NUM_BP(NUM_BP)) u_lane (
        .drive_mode (drive_mode),
        .in_bank    (in_bank),
        .wr_data    (wr_data),
        .lane_mask  (lane_mask),
        .lane_data  (lane_data)
    );

    seg_col_sel #(.NUM_BP(NUM_BP)) u_col (
        .drive_mode (drive_mode),
        .out_bank   (out_bank),
        .rd_bp      (rd_bp),
        .col        (col)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int k = 0; k < NUM_BP; k++) begin
                if (lane_mask[k])
                    s_d.mem[wr_addr][k] = lane_data[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int n = 0; n < NUM_SEG; n++)
            rd_seg[n] = s_q.mem[n][col];
    end

    // R11: no strobe, no change
    assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.mem));

    // R6: four-backplane writes replace the whole word
    assert_full_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && drive_mode == 2'd3) |=> (s_q.mem[$past(wr_addr)] == $past(wr_data)));

    // R10: three-backplane writes ignore the input bank
    assert_mux3_no_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && drive_mode == 2'd2) |=> (s_q.mem[$past(wr_addr)][2:0] == $past(wr_data[2:0])));
endmodule

// File: tb/test_banked_seg_ram.sv
`timescale 1ns/1ps
module test_banked_seg_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  drive_mode = 2'd3;
    logic        ptr_load = 1'b0;
    logic [4:0]  ptr_value = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_data = '0;
    logic        in_bank = 1'b0;
    logic        out_bank = 1'b0;
    logic [1:0]  rd_bp = '0;
    logic [31:0] rd_seg;

    always #4 clk = ~clk;

    banked_seg_ram i_banked_seg_ram (
        .clk(clk), .rst_n(rst_n), .drive_mode(drive_mode),
        .ptr_load(ptr_load), .ptr_value(ptr_value), .wr_en(wr_en),
        .wr_data(wr_data), .in_bank(in_bank), .out_bank(out_bank),
        .rd_bp(rd_bp), .rd_seg(rd_seg)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [3:0]  ref_mem [32];
    logic [4:0]  ref_ptr;

    // monitor: compare the scan row against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rd_seg !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rd_seg=%h expected=%h", it.tag, rd_seg, it.exp);
                end
            end
        end
    end

    task automatic model_write(input logic [3:0] d, input bit ld, input logic [4:0] lv);
        logic [4:0] a;
        int act, off;
        a   = ld ? lv : ref_ptr;
        act = int'(drive_mode) + 1;
        off = (in_bank && drive_mode <= 2'd1) ? 2 : 0;
        for (int k = 0; k < 4; k++)
            if (k >= off && k < off + act) ref_mem[a][k] = d[k - off];
        ref_ptr = (a == 5'd31) ? 5'd0 : a + 5'd1;
    endtask

    function automatic logic [31:0] model_row(input logic [1:0] bp);
        logic [31:0] r;
        int c;
        c = int'(bp);
        if (out_bank && ((drive_mode == 2'd0 && bp == 2'd0) || (drive_mode == 2'd1 && bp < 2'd2)))
            c = c + 2;
        for (int n = 0; n < 32; n++) r[n] = ref_mem[n][c];
        return r;
    endfunction

    // driver: one write strobe, optionally with a pointer load
    task automatic do_write(input logic [3:0] d, input bit ld, input logic [4:0] lv);
        wr_en = 1'b1; wr_data = d; ptr_load = ld; ptr_value = lv;
        model_write(d, ld, lv);
        @(posedge clk); #1;
        wr_en = 1'b0; ptr_load = 1'b0;
    endtask

    task automatic do_load(input logic [4:0] lv);
        ptr_load = 1'b1; ptr_value = lv;
        ref_ptr = lv;
        @(posedge clk); #1;
        ptr_load = 1'b0;
    endtask

    // driver: request a scan row and queue its expected value
    task automatic do_read(input logic [1:0] bp, input string tag);
        item_t it;
        rd_bp  = bp;
        it.exp = model_row(bp);
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        for (int n = 0; n < 32; n++) ref_mem[n] = 4'h0;
        ref_ptr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        for (int b = 0; b < 4; b++) do_read(2'(b), "R1 reset contents");

        // first write lands at address 0
        drive_mode = 2'd3;
        do_write(4'h1, 0, '0);
        do_read(2'd0, "R1 pointer starts at 0");

        // sequence across the top address
        do_load(5'd30);
        do_write(4'h5, 0, '0);
        do_write(4'hA, 0, '0);
        do_write(4'h3, 0, '0);
        do_write(4'hC, 0, '0);
        for (int b = 0; b < 4; b++) do_read(2'(b), "R3 R4 R2 run with wrap");

        // load and write in the same cycle
        do_write(4'h9, 1, 5'd5);
        do_write(4'h6, 0, '0);
        do_read(2'd0, "R5 same-cycle load");
        do_read(2'd3, "R5 same-cycle load");

        // three-backplane write keeps bit 3, ignores banks
        do_write(4'h8, 1, 5'd10);
        drive_mode = 2'd2; in_bank = 1'b1;
        do_write(4'h2, 1, 5'd10);
        in_bank = 1'b0;
        do_read(2'd1, "R6 R10 mux3 lanes");
        do_read(2'd3, "R6 R10 mux3 keeps bit3");
        out_bank = 1'b1;
        do_read(2'd0, "R10 mux3 out_bank ignored");
        drive_mode = 2'd3;
        do_read(2'd1, "R10 mux4 out_bank ignored");
        out_bank = 1'b0;

        // static mode, both banks
        drive_mode = 2'd0;
        do_write(4'h1, 1, 5'd12);
        in_bank = 1'b1;
        do_write(4'h1, 0, '0);
        do_read(2'd0, "R9 in_bank does not affect read");
        in_bank = 1'b0;
        do_read(2'd0, "R6 static bank0");
        do_read(2'd2, "R7 static bank1");
        out_bank = 1'b1;
        do_read(2'd0, "R8 static shows bit2");
        do_read(2'd1, "R8 static other bp unchanged");
        do_write(4'h1, 1, 5'd14);
        do_read(2'd0, "R9 out_bank does not steer write");
        out_bank = 1'b0;
        do_read(2'd0, "R9 write went to bit0");

        // two-backplane mode, both banks
        drive_mode = 2'd1;
        in_bank = 1'b1;
        do_write(4'h3, 1, 5'd20);
        in_bank = 1'b0;
        do_write(4'h2, 0, '0);
        do_read(2'd1, "R6 mux2 bank0");
        do_read(2'd3, "R7 mux2 bank1");
        out_bank = 1'b1;
        do_read(2'd0, "R8 mux2 bp0 shows bit2");
        do_read(2'd1, "R8 mux2 bp1 shows bit3");
        do_read(2'd2, "R8 mux2 bp2 unchanged");
        out_bank = 1'b0;

        // idle cycles with noisy inputs
        drive_mode = 2'd3;
        wr_data = 4'hF; in_bank = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        in_bank = 1'b0;
        for (int b = 0; b < 4; b++) do_read(2'(b), "R11 no write without strobe");

        @(posedge clk); #1;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule